// File: doc/BRIEF.md
# Shared Set/Reset and Latch-Enable Line Generator with Macrocell Array

This block builds three asynchronous control lines that are shared by a small array of storage macrocells. Each line is fed from an incoming product term, in true or inverted form where that is allowed, or from an incoming sum term where that is allowed. Line 2 also serves as the latch enable for every macrocell that is configured as a latch. The polarity of that enable follows the line's own mode.

The lines carry no fixed meaning. Each macrocell picks one line or none, and picks whether an active line forces it to 1 or to 0. As a result, one line can set one cell and clear another in the same instant. Each macrocell is either a rising-edge flip-flop or a level-sensitive latch.

A line mode that its line cannot support is reported on a per-line error pin, and that line then stays inactive. The product and sum terms arrive as plain inputs. All configuration pins are static control inputs.

Top module: `srl_ctrl_block`

## Requirements
- R1: While `rst_n` is low, every bit of `q` is 0 in both flip-flop and latch mode.
- R2: Line mode codes are 2 bits per line, with line k at `line_mode[2k+1:2k]`. Code 00 holds the line at 0, 01 drives it with the product term `pt_in[k]`, 10 drives it with the inverse of `pt_in[k]`, and 11 drives it with the sum term `st_in[k]`. The value of each line is visible on `line_out[k]`.
- R3: Line 0 supports codes 00, 01 and 11. Code 10 on line 0 raises `cfg_err[0]` and holds `line_out[0]` at 0.
- R4: Line 1 supports all four codes, and `cfg_err[1]` stays 0.
- R5: Line 2 supports codes 00, 01 and 10 only. Code 11 on line 2 raises `cfg_err[2]` and holds `line_out[2]` at 0.
- R6: Macrocell i picks its control line through `mc_sel[2i+1:2i]`: 0 selects no line, and 1, 2 and 3 select line 0, line 1 and line 2.
- R7: `mc_set[i]`=1 makes an active selected line force `q[i]` to 1, and 0 makes it force `q[i]` to 0. The same line may force opposite values into different cells at once.
- R8: While its selected line is high, a macrocell's output takes the forced value at once, with no clock edge, and this overrides `d`. This holds in both modes. A flip-flop keeps the forced value after the line drops, until the next rising clock edge.
- R9: A macrocell with `mc_latch[i]`=0 loads `d[i]` on each rising clock edge when its selected line is inactive.
- R10: A macrocell with `mc_latch[i]`=1 is transparent while `line_out[2]` is 1 and holds while it is 0, whatever the clock does. Inverted mode on line 2 therefore makes the latch open while `pt_in[2]` is 0.
- R11: A macrocell with no selected line is unaffected by activity on any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for flip-flop mode cells |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_in | input | 3 | Product term for each line |
| st_in | input | 2 | Sum terms for lines 0 and 1 |
| line_mode | input | 6 | Two-bit source code per line |
| mc_sel | input | 2*NUM_MC | Per-cell line choice |
| mc_set | input | NUM_MC | Per-cell forced value, 1 = set |
| mc_latch | input | NUM_MC | Per-cell storage type, 1 = latch |
| d | input | NUM_MC | Per-cell data |
| q | output | NUM_MC | Per-cell stored value |
| line_out | output | 3 | The three shared control lines |
| cfg_err | output | 3 | Per-line unsupported-mode flag |

## Verification
The clocked properties assume that terms, data and configuration change only between clock edges, never at them. They also assume that no control line rises and falls again within a single clock period, because the flip-flop load check relates the output at one edge to the data at the edge before. The directed tasks drive every change a fraction of a period after a rising edge. They hold each line pulse across at least one rising edge before releasing it, and they sample within the same period.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int NUM_LINES = 3;
  localparam int NUM_SUM   = 2;

  typedef enum logic [1:0] {
    LM_OFF = 2'b00,
    LM_PT  = 2'b01,
    LM_PTN = 2'b10,
    LM_SUM = 2'b11
  } line_mode_e;
endpackage

// File: rtl/srl_line_gen.sv
module srl_line_gen
  import srl_pkg::*;
#(
  parameter bit SUM_OK = 1'b1,
  parameter bit INV_OK = 1'b1
) (
  input  logic [1:0] mode,
  input  logic       pt,
  input  logic       st,
  output logic       line,
  output logic       bad
);
  always_comb begin
    line = 1'b0;
    bad  = 1'b0;
    unique case (line_mode_e'(mode))
      LM_OFF: line = 1'b0;
      LM_PT:  line = pt;
      LM_PTN: begin
        if (INV_OK) line = ~pt;
        else        bad  = 1'b1;
      end
      LM_SUM: begin
        if (SUM_OK) line = st;
        else        bad  = 1'b1;
      end
      default: line = 1'b0;
    endcase
  end
endmodule

// File: rtl/srl_macrocell.sv
module srl_macrocell
  import srl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines,
  input  logic [1:0]           sel,
  input  logic                 set_val,
  input  logic                 latch_mode,
  input  logic                 le,
  input  logic                 d,
  output logic                 q
);
  logic ctl;
  logic fq;
  logic lq;

  always_comb begin
    unique case (sel)
      2'd1:    ctl = lines[0];
      2'd2:    ctl = lines[1];
      2'd3:    ctl = lines[2];
      default: ctl = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n or posedge ctl) begin
    if (!rst_n)   fq <= 1'b0;
    else if (ctl) fq <= set_val;
    else          fq <= d;
  end

  always_latch begin
    if (!rst_n)   lq <= 1'b0;
    else if (ctl) lq <= set_val;
    else if (le)  lq <= d;
  end

  assign q = latch_mode ? lq : fq;

  // R8: forced value present whenever the selected line is high
  p_async_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl |-> (q == set_val));

  // R9: flip-flop loads data when no control is active at either edge
  p_ff_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !latch_mode && !$past(latch_mode) && !$past(ctl) && !ctl)
      |-> (q == $past(d)));

  // R10: open latch passes data through
  p_latch_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && !ctl && le) |-> (q == d));
endmodule

// File: rtl/srl_ctrl_block.sv
module srl_ctrl_block
  import srl_pkg::*;
#(
  parameter int NUM_MC = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_LINES-1:0]   pt_in,
  input  logic [NUM_SUM-1:0]     st_in,
  input  logic [2*NUM_LINES-1:0] line_mode,
  input  logic [2*NUM_MC-1:0]    mc_sel,
  input  logic [NUM_MC-1:0]      mc_set,
  input  logic [NUM_MC-1:0]      mc_latch,
  input  logic [NUM_MC-1:0]      d,
  output logic [NUM_MC-1:0]      q,
  output logic [NUM_LINES-1:0]   line_out,
  output logic [NUM_LINES-1:0]   cfg_err
);
  localparam int LE_LINE = NUM_LINES - 1;

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    logic st_k;
    if (k < NUM_SUM) begin : g_sum
      assign st_k = st_in[k];
    end else begin : g_nosum
      assign st_k = 1'b0;
    end

    srl_line_gen #(
      .SUM_OK (k < NUM_SUM),
      .INV_OK (k != 0)
    ) u_gen (
      .mode (line_mode[2*k +: 2]),
      .pt   (pt_in[k]),
      .st   (st_k),
      .line (line_out[k]),
      .bad  (cfg_err[k])
    );

    // R3 R5: a flagged line stays quiet
    p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err[k] |-> !line_out[k]);
  end

  for (genvar i = 0; i < NUM_MC; i++) begin : g_mc
    srl_macrocell u_mc (
      .clk        (clk),
      .rst_n      (rst_n),
      .lines      (line_out),
      .sel        (mc_sel[2*i +: 2]),
      .set_val    (mc_set[i]),
      .latch_mode (mc_latch[i]),
      .le         (line_out[LE_LINE]),
      .d          (d[i]),
      .q          (q[i])
    );

    // R11: an unselected flip-flop follows data regardless of the lines
    p_unsel_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && mc_sel[2*i +: 2] == 2'd0 && $past(mc_sel[2*i +: 2]) == 2'd0
        && !mc_latch[i] && !$past(mc_latch[i])) |-> (q[i] == $past(d[i])));
  end
endmodule

// File: tb/tb_srl_ctrl_block.sv
`timescale 1ns/100ps
module tb_srl_ctrl_block;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   pt_in;
  logic [1:0]   st_in;
  logic [5:0]   line_mode;
  logic [2*N-1:0] mc_sel;
  logic [N-1:0] mc_set, mc_latch, d, q;
  logic [2:0]   line_out, cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  srl_ctrl_block #(.NUM_MC(N)) dut (
    .clk(clk), .rst_n(rst_n), .pt_in(pt_in), .st_in(st_in),
    .line_mode(line_mode), .mc_sel(mc_sel), .mc_set(mc_set),
    .mc_latch(mc_latch), .d(d), .q(q), .line_out(line_out), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #0.5;
  endtask

  task automatic settle();
    #0.4;
  endtask

  task automatic cfg_clear();
    pt_in = '0; st_in = '0; line_mode = '0;
    mc_sel = '0; mc_set = '0; mc_latch = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_clear(); d = '1; mc_latch = 6'b110000;
    tick();
    chk("R1 q under reset", q, 0);
    rst_n = 1'b1; mc_latch = '0;
    tick();
  endtask

  task automatic t_lines();
    cfg_clear();
    line_mode[3:2] = 2'b01; pt_in[1] = 1'b1; settle();
    chk("R2 line1 true term", line_out[1], 1);
    line_mode[3:2] = 2'b10; settle();
    chk("R2 line1 inverted term", line_out[1], 0);
    pt_in[1] = 1'b0; settle();
    chk("R4 line1 inverted low term", line_out[1], 1);
    line_mode[3:2] = 2'b11; st_in[1] = 1'b1; settle();
    chk("R4 line1 sum term", {cfg_err[1], line_out[1]}, 2'b01);
    line_mode[3:2] = 2'b00; settle();
    chk("R2 line1 off", line_out[1], 0);
    line_mode[1:0] = 2'b10; pt_in[0] = 1'b0; settle();
    chk("R3 line0 inverted flagged", {cfg_err[0], line_out[0]}, 2'b10);
    line_mode[1:0] = 2'b11; st_in[0] = 1'b1; settle();
    chk("R3 line0 sum ok", {cfg_err[0], line_out[0]}, 2'b01);
    line_mode[5:4] = 2'b11; pt_in[2] = 1'b1; settle();
    chk("R5 line2 sum flagged", {cfg_err[2], line_out[2]}, 2'b10);
    line_mode[5:4] = 2'b10; pt_in[2] = 1'b0; settle();
    chk("R5 line2 inverted", {cfg_err[2], line_out[2]}, 2'b01);
    cfg_clear();
    tick();
  endtask

  task automatic t_ff();
    cfg_clear();
    d = 6'h2A; tick();
    chk("R9 ff load pattern a", q, 6'h2A);
    d = 6'h15; tick();
    chk("R9 ff load pattern b", q, 6'h15);
  endtask

  task automatic t_async();
    cfg_clear();
    mc_sel[1:0] = 2'd1; mc_sel[3:2] = 2'd1;
    mc_set[0] = 1'b1; mc_set[1] = 1'b0;
    line_mode[1:0] = 2'b01;
    d = 6'b000010; tick();
    chk("R9 preload", q, 6'b000010);
    pt_in[0] = 1'b1; settle();
    chk("R7 same line sets one clears other", q[1:0], 2'b01);
    d = 6'b111110; tick();
    chk("R8 force overrides clocked data", q, 6'b111101);
    pt_in[0] = 1'b0; settle();
    chk("R8 forced value held after drop", q, 6'b111101);
    tick();
    chk("R9 reload after release", q, 6'b111110);
  endtask

  task automatic t_none();
    cfg_clear();
    line_mode = 6'b010101; pt_in = 3'b111; mc_set = '1;
    d = 6'h15; tick();
    chk("R11 unselected ignores lines", q, 6'h15);
    d = 6'h00; tick();
    chk("R11 unselected ignores lines b", q, 6'h00);
  endtask

  task automatic t_sel();
    cfg_clear();
    mc_sel[5:4] = 2'd2; mc_sel[7:6] = 2'd3; mc_set[2] = 1'b1; mc_set[3] = 1'b1;
    line_mode = 6'b010100;
    d = '0; tick();
    pt_in[1] = 1'b1; settle();
    chk("R6 line1 reaches only its cell", q, 6'b000100);
    tick();
    pt_in[1] = 1'b0; pt_in[2] = 1'b1; settle();
    chk("R6 line2 reaches its cell", q, 6'b001100);
    tick();
    pt_in[2] = 1'b0; tick();
    chk("R6 cells reload", q, 6'b000000);
  endtask

  task automatic t_latch();
    cfg_clear();
    mc_latch = 6'b110000;
    line_mode[5:4] = 2'b01; pt_in[2] = 1'b1;
    d = 6'b010000; settle();
    chk("R10 latch open a", q[5:4], 2'b01);
    d = 6'b100000; settle();
    chk("R10 latch open b", q[5:4], 2'b10);
    pt_in[2] = 1'b0; settle();
    d = 6'b010000; settle();
    chk("R10 latch closed holds", q[5:4], 2'b10);
    tick();
    chk("R10 latch ignores clock", q[5:4], 2'b10);
    line_mode[5:4] = 2'b10; settle();
    chk("R10 inverted enable opens", q[5:4], 2'b01);
    pt_in[2] = 1'b1; settle();
    d = 6'b110000; settle();
    chk("R10 inverted enable closed", q[5:4], 2'b01);
    tick();
    pt_in[2] = 1'b0; mc_sel[11:10] = 2'd1; mc_set[5] = 1'b0;
    line_mode[1:0] = 2'b01; pt_in[0] = 1'b1; settle();
    chk("R8 clear overrides open latch", q[5:4], 2'b01);
    tick();
    pt_in[0] = 1'b0; tick();
  endtask

  initial begin
    t_reset();
    t_lines();
    t_ff();
    t_async();
    t_none();
    t_sel();
    t_latch();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule